// File: doc/BRIEF.md
# External interrupt sense controller

This block turns four external input lines into interrupt requests. Each line has a two-bit sense mode: active-low level, any change, falling edge or rising edge. A separate group of eight inputs shares one pin-change flag. That flag is set whenever an input selected by an eight-bit mask toggles in either direction. The detectors watch the pin value no matter what drives it, so software can raise an interrupt by driving the pin itself.

Software reaches the block through a small register port with four addresses. Address 0 holds the sense word and address 1 the enable mask. Address 2 holds the flags, and writing a one to a flag bit clears it. Address 3 holds the pin-change mask. Edge modes latch a flag. Level mode gives a live request that follows the pin and latches nothing. Every request is gated by its enable bit and by the global enable input. Rewriting a line's mode can expose a new level to the detector, and that can set the line's flag.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset all four registers read 0 and every request output is low.
- R2: Address 0 holds the sense word, with line n at bits 2n+1:2n. Address 1 holds the enable mask: bits 3:0 for lines 3..0 and bit 4 for the pin-change group. Address 3 holds the pin-change mask. All three read back the value written.
- R3: A request is driven only when its enable bit and gie_i are both 1. With gie_i low, irq_o and pc_irq_o are all 0.
- R4: In mode 00, irq_o[n] is high while the synchronised pin is low. It follows the pin two clock edges after the pin changes, and the mode sets no flag.
- R5: Mode 10 (falling) sets flag bit n on a high-to-low change, and mode 11 (rising) sets it on a low-to-high change. The flag is readable at address 2 after the third clock edge following the pin change. The opposite edge sets nothing.
- R6: Mode 01 sets flag bit n on a change in either direction.
- R7: Writing 1 to a bit at address 2 clears that flag. Writing 0 leaves it unchanged.
- R8: When an edge is detected in the same cycle as a clear of the same flag, the flag stays set.
- R9: Changing a line from rising to falling mode while its pin is low sets its flag on the edge after the write.
- R10: The pin-change flag (address 2, bit 4) sets when a masked pc_pin_i bit toggles either way. Unmasked toggles are ignored. pc_irq_o is flag AND enable bit 4 AND gie_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie_i | input | 1 | Global interrupt enable |
| pin_i | input | 4 | External interrupt lines |
| pc_pin_i | input | 8 | Pin-change group inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_o | output | 4 | Per-line gated request |
| pc_irq_o | output | 1 | Gated pin-change request |

## Verification
A pin change sampled at clock edge k reaches the synchroniser output at edge k+1. A level request is therefore visible after edge k+1, and an edge flag and its request appear after edge k+2. A register write lands on the edge it is presented at. A mode-change flag follows one edge later. The bench drives every input on the falling clock edge and waits exactly that many rising edges before it reads back at the next falling edge. The level-mode check also samples one cycle early to confirm the request is not yet there. The edge-versus-clear race is lined up so the clear strobe meets the same rising edge that latches the flag.

// File: rtl/eisc_pkg.sv
`timescale 1ns/1ps
package eisc_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADR_SENSE  = 2'd0;
  localparam logic [1:0] ADR_ENABLE = 2'd1;
  localparam logic [1:0] ADR_FLAGS  = 2'd2;
  localparam logic [1:0] ADR_PCMASK = 2'd3;
endpackage

// File: rtl/eisc_sync.sv
`timescale 1ns/1ps
module eisc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/eisc_line.sv
`timescale 1ns/1ps
module eisc_line
  import eisc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  input  logic   gate_i,
  output logic   flag_o,
  output logic   req_o
);
  logic pin_prev_q, qual_prev_q, flag_q;
  logic qual, hit, flag_d, level_live;

  // Qualified value depends on the mode in force, so a mode rewrite can
  // present a fresh rising qualified value to the detector.
  always_comb begin
    qual = (mode_i == SNS_RISE) ? pin_s_i : ~pin_s_i;
    case (mode_i)
      SNS_ANY:            hit = pin_s_i ^ pin_prev_q;
      SNS_FALL, SNS_RISE: hit = qual & ~qual_prev_q;
      default:            hit = 1'b0;
    endcase
    flag_d     = hit | (flag_q & ~clr_i);
    level_live = (mode_i == SNS_LOW) & ~pin_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev_q  <= 1'b0;
      qual_prev_q <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      pin_prev_q  <= pin_s_i;
      qual_prev_q <= qual;
      flag_q      <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = gate_i & (flag_q | level_live);
endmodule

// File: rtl/eisc_pcgrp.sv
`timescale 1ns/1ps
module eisc_pcgrp #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_s_i,
  input  logic [N-1:0] mask_i,
  input  logic         clr_i,
  input  logic         gate_i,
  output logic         flag_o,
  output logic         req_o
);
  logic [N-1:0] prev_q;
  logic         flag_q, hit, flag_d;

  always_comb begin
    hit    = |((pins_s_i ^ prev_q) & mask_i);
    flag_d = hit | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pins_s_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = gate_i & flag_q;
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense
  import eisc_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int N_PC    = 8,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gie_i,
  input  logic [N_LINES-1:0] pin_i,
  input  logic [N_PC-1:0]    pc_pin_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [N_LINES-1:0] irq_o,
  output logic               pc_irq_o
);
  localparam int CTRL_W = 2 * N_LINES;
  localparam int PC_BIT = N_LINES;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_n_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_core = rst_pipe_q[1];

  // Configuration registers
  logic [CTRL_W-1:0] sense_q, sense_d;
  logic [PC_BIT:0]   en_q, en_d;
  logic [N_PC-1:0]   pcmsk_q, pcmsk_d;
  logic              we_sense, we_en, we_pcmsk, we_flags;
  logic [PC_BIT:0]   clr_vec;
  logic              unused_wdata_bits;

  always_comb begin
    we_sense = wr_en_i && (wr_addr_i == ADR_SENSE);
    we_en    = wr_en_i && (wr_addr_i == ADR_ENABLE);
    we_flags = wr_en_i && (wr_addr_i == ADR_FLAGS);
    we_pcmsk = wr_en_i && (wr_addr_i == ADR_PCMASK);
    sense_d  = we_sense ? wr_data_i[CTRL_W-1:0] : sense_q;
    en_d     = we_en    ? wr_data_i[PC_BIT:0]   : en_q;
    pcmsk_d  = we_pcmsk ? wr_data_i[N_PC-1:0]   : pcmsk_q;
    clr_vec  = we_flags ? wr_data_i[PC_BIT:0]   : '0;
  end
  assign unused_wdata_bits = ^wr_data_i;

  always_ff @(posedge clk or negedge rst_n_core) begin
    if (!rst_n_core) begin
      sense_q <= '0;
      en_q    <= '0;
      pcmsk_q <= '0;
    end else begin
      sense_q <= sense_d;
      en_q    <= en_d;
      pcmsk_q <= pcmsk_d;
    end
  end

  // Synchronisers
  logic [N_LINES-1:0] pin_s;
  logic [N_PC-1:0]    pc_s;

  eisc_sync #(.W(N_LINES)) u_sync_ln (
    .clk(clk), .rst_n(rst_n_core), .d_i(pin_i), .q_o(pin_s)
  );
  eisc_sync #(.W(N_PC)) u_sync_pc (
    .clk(clk), .rst_n(rst_n_core), .d_i(pc_pin_i), .q_o(pc_s)
  );

  // Per-line detectors
  logic [PC_BIT:0] flags_all;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    eisc_line u_line (
      .clk    (clk),
      .rst_n  (rst_n_core),
      .pin_s_i(pin_s[g]),
      .mode_i (sense_e'(sense_q[2*g +: 2])),
      .clr_i  (clr_vec[g]),
      .gate_i (en_q[g] & gie_i),
      .flag_o (flags_all[g]),
      .req_o  (irq_o[g])
    );
  end

  eisc_pcgrp #(.N(N_PC)) u_pcgrp (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .pins_s_i(pc_s),
    .mask_i  (pcmsk_q),
    .clr_i   (clr_vec[PC_BIT]),
    .gate_i  (en_q[PC_BIT] & gie_i),
    .flag_o  (flags_all[PC_BIT]),
    .req_o   (pc_irq_o)
  );

  // Read mux
  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADR_SENSE:  rd_data_o[CTRL_W-1:0] = sense_q;
      ADR_ENABLE: rd_data_o[PC_BIT:0]   = en_q;
      ADR_FLAGS:  rd_data_o[PC_BIT:0]   = flags_all;
      default:    rd_data_o[N_PC-1:0]   = pcmsk_q;
    endcase
  end
endmodule

// File: rtl/eisc_chk.sv
`timescale 1ns/1ps
module eisc_chk #(
  parameter int N_LINES = 4,
  parameter int N_PC    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gie_i,
  input logic [N_LINES-1:0]   irq_o,
  input logic                 pc_irq_o,
  input logic [2*N_LINES-1:0] sense_q,
  input logic [N_LINES:0]     flags,
  input logic [N_PC-1:0]      pcmsk_q,
  input logic [N_LINES:0]     clr_vec
);
  // R3: global enable low silences every request
  a_r3_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (irq_o == '0 && !pc_irq_o));

  for (genvar i = 0; i < N_LINES; i++) begin : g_ln
    // R4: a line in level mode never latches a flag
    a_r4_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(sense_q[2*i +: 2] != 2'b00));
  end

  for (genvar i = 0; i <= N_LINES; i++) begin : g_fl
    // R7: a flag only drops after a one was written to it
    a_r7_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(clr_vec[i]));
  end

  // R10: the shared flag needs at least one mask bit
  a_r10_pc_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[N_LINES]) |-> $past(pcmsk_q != '0));
endmodule

bind ext_irq_sense eisc_chk #(.N_LINES(N_LINES), .N_PC(N_PC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gie_i   (gie_i),
  .irq_o   (irq_o),
  .pc_irq_o(pc_irq_o),
  .sense_q (sense_q),
  .flags   (flags_all),
  .pcmsk_q (pcmsk_q),
  .clr_vec (clr_vec)
);

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/1ps
module ext_irq_sense_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gie = 1'b0;
  logic [3:0] pin = 4'hF;
  logic [7:0] pcp = 8'hFF;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] irq;
  logic       pc_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .gie_i(gie), .pin_i(pin), .pc_pin_i(pcp),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .pc_irq_o(pc_irq)
  );

  // vector: {line[1:0], mode[1:0], pin_before, pin_after, exp_flag, exp_irq}
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd3, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'd1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'd3, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 register reset", d, 0);
    end
    check("R1 irq reset", irq, 0);
    check("R1 pc_irq reset", pc_irq, 0);

    // R2 readback
    wr(2'd1, 8'h1F); rd(2'd1, d); check("R2 enable readback", d, 8'h1F);
    wr(2'd3, 8'hA5); rd(2'd3, d); check("R2 pcmask readback", d, 8'hA5);
    wr(2'd0, 8'hE4); rd(2'd0, d); check("R2 sense readback", d, 8'hE4);
    wr(2'd3, 8'h00);
    gie = 1'b1;

    // Table walk: R4, R5, R6
    for (int k = 0; k < 8; k++) begin
      int line;
      logic [1:0] mode;
      string tag;
      line = int'(VEC[k][7:6]);
      mode = VEC[k][5:4];
      tag = (mode == 2'b00) ? "R4 level" : (mode == 2'b01) ? "R6 any" : "R5 edge";
      wr(2'd0, 8'(mode) << (2 * line));
      pin[line] = VEC[k][3];
      tick(4);
      wr(2'd2, 8'h1F);
      pin[line] = VEC[k][2];
      tick(3);
      rd(2'd2, d);
      check({tag, " flag"}, d[line], VEC[k][1]);
      check({tag, " irq"}, irq[line], VEC[k][0]);
      pin[line] = 1'b1;
      tick(4);
    end

    // R4 timing and live drop
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h1F);
    pin[0] = 1'b0;
    tick(1);
    check("R4 level not yet due", irq[0], 0);
    tick(1);
    check("R4 level due after two edges", irq[0], 1);
    // R3 gating
    gie = 1'b0; #1;
    check("R3 gie low blocks", irq[0], 0);
    gie = 1'b1; #1;
    check("R3 gie high passes", irq[0], 1);
    wr(2'd1, 8'h1E);
    check("R3 enable bit clear blocks", irq[0], 0);
    wr(2'd1, 8'h1F);
    pin[0] = 1'b1;
    tick(2);
    check("R4 level drops with pin", irq[0], 0);
    rd(2'd2, d);
    check("R4 level leaves no flag", d[0], 0);

    // R7 write-one-to-clear
    wr(2'd0, 8'h30);              // line 2 rising
    pin[2] = 1'b0;
    tick(4);
    wr(2'd2, 8'h1F);
    pin[2] = 1'b1;
    tick(3);
    rd(2'd2, d); check("R7 flag set before clear", d[2], 1);
    wr(2'd2, 8'h1B);
    rd(2'd2, d); check("R7 zero write keeps flag", d[2], 1);
    wr(2'd2, 8'h04);
    rd(2'd2, d); check("R7 one write clears flag", d[2], 0);

    // R8 edge beats clear
    wr(2'd0, 8'h02);              // line 0 falling
    pin[0] = 1'b1;
    tick(4);
    wr(2'd2, 8'h1F);
    pin[0] = 1'b0;
    tick(3);
    rd(2'd2, d); check("R8 first fall sets flag", d[0], 1);
    pin[0] = 1'b1;
    tick(3);
    pin[0] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd2, d); check("R8 edge wins over clear", d[0], 1);
    wr(2'd2, 8'h01);
    rd(2'd2, d); check("R8 later clear works", d[0], 0);
    pin[0] = 1'b1;
    tick(4);

    // R9 mode rewrite exposes level
    wr(2'd0, 8'h0C);              // line 1 rising
    pin[1] = 1'b0;
    tick(4);
    wr(2'd2, 8'h1F);
    rd(2'd2, d); check("R9 flag clear before rewrite", d[1], 0);
    wr(2'd0, 8'h08);              // line 1 falling
    tick(1);
    rd(2'd2, d); check("R9 rewrite sets flag", d[1], 1);
    pin[1] = 1'b1;
    tick(4);

    // R10 pin-change group
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
    tick(4);
    wr(2'd2, 8'h1F);
    pcp[3] = 1'b0;
    tick(3);
    rd(2'd2, d); check("R10 unmasked toggle ignored", d[4], 0);
    check("R10 no pc_irq on unmasked", pc_irq, 0);
    pcp[0] = 1'b0;
    tick(3);
    rd(2'd2, d); check("R10 masked fall sets flag", d[4], 1);
    check("R10 pc_irq asserted", pc_irq, 1);
    wr(2'd2, 8'h10);
    rd(2'd2, d); check("R10 flag cleared", d[4], 0);
    pcp[0] = 1'b1;
    tick(3);
    rd(2'd2, d); check("R10 masked rise sets flag", d[4], 1);
    gie = 1'b0; #1;
    check("R10 pc_irq gated by gie", pc_irq, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule